// File: doc/BRIEF.md
# Receive Character Buffer with Idle Timeout

This block sits between a serial receiver and a host read port. Each time the receiver finishes a character it offers the data byte together with its parity-error, framing-error and break flags. The block stores these in a first-in first-out queue. The host sees the oldest entry on a head port and removes it with a read strobe. A data-ready flag and the fill level show whether entries are waiting.

Two interrupt outputs signal the host. The data-available interrupt is raised when the fill level reaches a threshold chosen by a two-bit code. The timeout interrupt is raised when entries have been waiting, with no arrival and no host read, for a set number of character times. The receiver's baud logic supplies a one-cycle tick for each character time. A clear strobe empties the queue, and so does any change of the enable input. A character that arrives while the queue is full is dropped and recorded in a sticky overrun flag.

Top module: `rx_char_buffer`

## Requirements
- R1: Entries leave in arrival order. The head port shows the oldest stored entry (data, parity, framing and break flags) whenever the fill level is nonzero, and an accepted read moves the head to the next entry.
- R2: Reset leaves the fill level at 0. An accepted arrival raises the fill level by one at the next clock edge, and an accepted read lowers it by one; both in the same cycle leave it unchanged. The level never exceeds the depth of 16. Data-ready is high exactly when the fill level is nonzero.
- R3: An arrival while the queue is full, with no read in the same cycle, is dropped and sets the overrun flag at the next edge. The flag stays set until a status-read strobe. If an overflow and a status read happen in the same cycle, the flag stays set.
- R4: A clear strobe empties the queue at the next edge. It takes precedence over an arrival or a read in the same cycle, and that arrival does not set overrun.
- R5: A change of the enable input in either direction empties the queue at the next edge, exactly as a clear strobe does.
- R6: Trigger code 00 selects 1 entry, 01 selects 4, 10 selects 8 and 11 selects 14. The data-available interrupt is high while the fill level is at or above the selected count.
- R7: Both interrupts are low unless the enable input and the data interrupt enable are both high.
- R8: An idle counter restarts on every accepted arrival, accepted read or clear. Otherwise it counts character ticks while the queue is non-empty and stops at 4. The timeout interrupt is high when the queue is non-empty and the counter has reached 4.
- R9: An accepted host read drops the timeout interrupt at the next edge, even if entries remain.
- R10: A read strobe while the queue is empty has no effect on the fill level, the head or the interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fifoEn | input | 1 | Queue enable level; any change clears the queue |
| clrRx | input | 1 | Clear strobe |
| trigSel | input | 2 | Trigger code for the data-available threshold |
| dataIntEn | input | 1 | Receive interrupt enable |
| pushValid | input | 1 | A completed character is offered |
| pushData | input | 8 | Character data |
| pushParErr | input | 1 | Parity error flag of the character |
| pushFrmErr | input | 1 | Framing error flag of the character |
| pushBrk | input | 1 | Break flag of the character |
| charTick | input | 1 | One-cycle pulse per character time |
| popReq | input | 1 | Host read of the head entry |
| statusRead | input | 1 | Host status read; clears overrun |
| rdData | output | 8 | Head entry data |
| rdParErr | output | 1 | Head entry parity error flag |
| rdFrmErr | output | 1 | Head entry framing error flag |
| rdBrk | output | 1 | Head entry break flag |
| fillLevel | output | 5 | Number of stored entries |
| dataReady | output | 1 | Queue holds at least one entry |
| overrun | output | 1 | Sticky overflow flag |
| dataIrq | output | 1 | Data-available interrupt |
| timeoutIrq | output | 1 | Idle timeout interrupt |

## Verification
The bench pushes the queue to exactly 16 entries and offers one more. A design that wrapped its pointers would overwrite the oldest entry and show the wrong head, and one that lost the overrun flag would miss the drop. It steps the character tick one at a time around the fourth tick. An off-by-one idle counter raises the timeout interrupt a tick early or late, and a counter that ignores host reads keeps the interrupt high after a read that leaves data behind. It also toggles the enable both ways while data is stored and collides the clear strobe with an arrival. A design without edge detection on the enable, or with the wrong precedence, keeps stale entries or sets a false overrun.

// File: rtl/rx_buf_pkg.sv
package rx_buf_pkg;
  parameter int DATA_W = 8;

  // one stored character with the receiver's error flags
  typedef struct packed {
    logic              brk;
    logic              frmErr;
    logic              parErr;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic push;
    logic pop;
  } fifo_strobe_t;

  // threshold count for the two-bit trigger code
  function automatic int unsigned trig_level(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/rx_buf_datapath.sv
module rx_buf_datapath
  import rx_buf_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  fifo_strobe_t strobe,
  input  rx_entry_t    pushEntry,
  output rx_entry_t    headEntry
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  rx_entry_t        storage [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.push) storage[wrPtr] <= pushEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strobe.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= bump(wrPtr);
      if (strobe.pop)  rdPtr <= bump(rdPtr);
    end
  end

  assign headEntry = storage[rdPtr];

  // R4: a clear leaves the pointers aligned
  assert_clear_aligns_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (wrPtr == rdPtr));

  // R1: a lone read advances the head pointer by one place
  assert_pop_advances_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pop && !strobe.clear) |=> (rdPtr == bump($past(rdPtr))));
endmodule

// File: rtl/rx_buf_ctrl.sv
module rx_buf_ctrl
  import rx_buf_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int TIMEOUT_CHARS = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         fifoEn,
  input  logic                         clrRx,
  input  logic [1:0]                   trigSel,
  input  logic                         dataIntEn,
  input  logic                         pushValid,
  input  logic                         popReq,
  input  logic                         charTick,
  input  logic                         statusRead,
  output fifo_strobe_t                 strobe,
  output logic [$clog2(DEPTH+1)-1:0]   fillLevel,
  output logic                         dataReady,
  output logic                         overrun,
  output logic                         dataIrq,
  output logic                         timeoutIrq
);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int IDLE_W = $clog2(TIMEOUT_CHARS + 1);

  logic              fifoEnQ;
  logic [IDLE_W-1:0] idleCnt;
  logic              isEmpty, isFull, doClear, doPush, doPop, dropChar, rxIrqEn;
  logic [CNT_W-1:0]  trigCount;

  always_comb begin
    isEmpty   = (fillLevel == '0);
    isFull    = (fillLevel == CNT_W'(DEPTH));
    doClear   = clrRx | (fifoEn != fifoEnQ);
    doPop     = popReq & ~isEmpty & ~doClear;
    doPush    = pushValid & (~isFull | doPop) & ~doClear;
    dropChar  = pushValid & ~doClear & ~doPush;
    trigCount = CNT_W'(trig_level(trigSel));
    rxIrqEn   = fifoEn & dataIntEn;
  end

  assign strobe = '{clear: doClear, push: doPush, pop: doPop};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoEnQ   <= 1'b0;
      fillLevel <= '0;
      idleCnt   <= '0;
      overrun   <= 1'b0;
    end else begin
      fifoEnQ <= fifoEn;
      if (doClear)                fillLevel <= '0;
      else if (doPush && !doPop)  fillLevel <= fillLevel + CNT_W'(1);
      else if (doPop && !doPush)  fillLevel <= fillLevel - CNT_W'(1);

      if (doClear || doPush || doPop)
        idleCnt <= '0;
      else if (charTick && !isEmpty && idleCnt != IDLE_W'(TIMEOUT_CHARS))
        idleCnt <= idleCnt + IDLE_W'(1);

      if (dropChar)        overrun <= 1'b1;
      else if (statusRead) overrun <= 1'b0;
    end
  end

  assign dataReady  = ~isEmpty;
  assign dataIrq    = rxIrqEn & (fillLevel >= trigCount);
  assign timeoutIrq = rxIrqEn & ~isEmpty & (idleCnt == IDLE_W'(TIMEOUT_CHARS));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= CNT_W'(DEPTH));

  assert_ready_after_push_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |=> dataReady);

  assert_clear_empties_R4: assert property (@(posedge clk) disable iff (!rstN)
    clrRx |=> (fillLevel == '0));

  assert_en_change_empties_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn != fifoEnQ) |=> !dataReady);

  assert_overrun_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && !clrRx && fifoEn == fifoEnQ && fillLevel == CNT_W'(DEPTH) && !popReq)
      |=> overrun);

  assert_timeout_needs_data_R8: assert property (@(posedge clk) disable iff (!rstN)
    timeoutIrq |-> dataReady);

  assert_read_drops_timeout_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |=> !timeoutIrq);
endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer
  import rx_buf_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int TIMEOUT_CHARS = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       fifoEn,
  input  logic                       clrRx,
  input  logic [1:0]                 trigSel,
  input  logic                       dataIntEn,
  input  logic                       pushValid,
  input  logic [DATA_W-1:0]          pushData,
  input  logic                       pushParErr,
  input  logic                       pushFrmErr,
  input  logic                       pushBrk,
  input  logic                       charTick,
  input  logic                       popReq,
  input  logic                       statusRead,
  output logic [DATA_W-1:0]          rdData,
  output logic                       rdParErr,
  output logic                       rdFrmErr,
  output logic                       rdBrk,
  output logic [$clog2(DEPTH+1)-1:0] fillLevel,
  output logic                       dataReady,
  output logic                       overrun,
  output logic                       dataIrq,
  output logic                       timeoutIrq
);
  fifo_strobe_t strobe;
  rx_entry_t    pushEntry;
  rx_entry_t    headEntry;

  assign pushEntry = '{brk: pushBrk, frmErr: pushFrmErr, parErr: pushParErr, data: pushData};

  rx_buf_ctrl #(.DEPTH(DEPTH), .TIMEOUT_CHARS(TIMEOUT_CHARS)) u_ctrl (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .clrRx(clrRx), .trigSel(trigSel),
    .dataIntEn(dataIntEn), .pushValid(pushValid), .popReq(popReq),
    .charTick(charTick), .statusRead(statusRead), .strobe(strobe),
    .fillLevel(fillLevel), .dataReady(dataReady), .overrun(overrun),
    .dataIrq(dataIrq), .timeoutIrq(timeoutIrq)
  );

  rx_buf_datapath #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pushEntry(pushEntry), .headEntry(headEntry)
  );

  assign rdData   = headEntry.data;
  assign rdParErr = headEntry.parErr;
  assign rdFrmErr = headEntry.frmErr;
  assign rdBrk    = headEntry.brk;
endmodule

// File: tb/rx_char_buffer_bench.sv
`timescale 1ns/1ps
module rx_char_buffer_bench;
  localparam int DEPTH = 16;
  localparam int TMO   = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN, fifoEn, clrRx, dataIntEn, pushValid, pushParErr, pushFrmErr, pushBrk;
  logic       charTick, popReq, statusRead;
  logic [1:0] trigSel;
  logic [7:0] pushData, rdData;
  logic       rdParErr, rdFrmErr, rdBrk, dataReady, overrun, dataIrq, timeoutIrq;
  logic [4:0] fillLevel;

  rx_char_buffer u_rx_char_buffer (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .clrRx(clrRx), .trigSel(trigSel),
    .dataIntEn(dataIntEn), .pushValid(pushValid), .pushData(pushData),
    .pushParErr(pushParErr), .pushFrmErr(pushFrmErr), .pushBrk(pushBrk),
    .charTick(charTick), .popReq(popReq), .statusRead(statusRead),
    .rdData(rdData), .rdParErr(rdParErr), .rdFrmErr(rdFrmErr), .rdBrk(rdBrk),
    .fillLevel(fillLevel), .dataReady(dataReady), .overrun(overrun),
    .dataIrq(dataIrq), .timeoutIrq(timeoutIrq)
  );

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // reference model state
  logic [10:0] mq [DEPTH];
  int mRd, mWr, mCnt, mIdle;
  bit mOvr, mEnPrev;

  function automatic int lvl(input logic [1:0] s);
    case (s) 2'b00: return 1; 2'b01: return 4; 2'b10: return 8; default: return 14; endcase
  endfunction

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelStep();
    bit clr, pop, push, ovf;
    clr = clrRx || (fifoEn != mEnPrev);
    mEnPrev = fifoEn;
    ovf = 0;
    if (clr) begin
      mCnt = 0; mRd = 0; mWr = 0; mIdle = 0;
    end else begin
      pop  = popReq && mCnt > 0;
      push = pushValid && (mCnt < DEPTH || pop);
      ovf  = pushValid && !push;
      if (pop) mRd = (mRd + 1) % DEPTH;
      if (push) begin
        mq[mWr] = {pushBrk, pushFrmErr, pushParErr, pushData};
        mWr = (mWr + 1) % DEPTH;
      end
      mCnt = mCnt + int'(push) - int'(pop);
      if (push || pop) mIdle = 0;
      else if (charTick && mCnt != 0 && mIdle < TMO) mIdle++;
    end
    if (ovf) mOvr = 1;
    else if (statusRead) mOvr = 0;
  endtask

  task automatic compareAll();
    bit en;
    en = fifoEn && dataIntEn;
    checkEq("R2 fill", int'(fillLevel), mCnt);
    checkEq("R2 ready", int'(dataReady), int'(mCnt != 0));
    if (mCnt != 0) checkEq("R1 head", int'({rdBrk, rdFrmErr, rdParErr, rdData}), int'(mq[mRd]));
    checkEq("R3 overrun", int'(overrun), int'(mOvr));
    checkEq("R6 dataIrq", int'(dataIrq), int'(en && mCnt >= lvl(trigSel)));
    checkEq("R8 timeout", int'(timeoutIrq), int'(en && mCnt != 0 && mIdle == TMO));
  endtask

  // inputs are set at a falling edge before calling; pulses drop afterwards
  task automatic cycle();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
    pushValid = 0; popReq = 0; clrRx = 0; charTick = 0; statusRead = 0;
  endtask

  task automatic push1(input logic [7:0] d);
    pushValid = 1; pushData = d;
    pushParErr = d[0]; pushFrmErr = d[1]; pushBrk = d[2];
    cycle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int r;
    void'($urandom(32'd20240611));
    rstN = 0; fifoEn = 0; clrRx = 0; dataIntEn = 0; pushValid = 0; pushData = 0;
    pushParErr = 0; pushFrmErr = 0; pushBrk = 0; charTick = 0; popReq = 0;
    statusRead = 0; trigSel = 2'b00;
    mRd = 0; mWr = 0; mCnt = 0; mIdle = 0; mOvr = 0; mEnPrev = 0;
    repeat (3) @(negedge clk);
    // reset state
    checkEq("R2 reset fill", int'(fillLevel), 0);
    checkEq("R2 reset ready", int'(dataReady), 0);
    checkEq("R3 reset overrun", int'(overrun), 0);
    checkEq("R7 reset irq", int'(dataIrq | timeoutIrq), 0);
    rstN = 1;
    @(negedge clk);
    fifoEn = 1; dataIntEn = 1; trigSel = 2'b01;
    cycle();

    // R1 and R6: order and the 4-entry threshold
    push1(8'h11); push1(8'h22); push1(8'h33);
    checkEq("R6 below trigger", int'(dataIrq), 0);
    push1(8'h44);
    checkEq("R6 at trigger", int'(dataIrq), 1);
    popReq = 1; cycle();
    checkEq("R1 second entry", int'(rdData), 8'h22);

    // R3: fill to 16 and overflow
    while (mCnt < DEPTH) push1(8'(mCnt + 8'h50));
    checkEq("R2 full level", int'(fillLevel), DEPTH);
    push1(8'hEE);
    checkEq("R3 dropped", int'(fillLevel), DEPTH);
    checkEq("R3 sticky set", int'(overrun), 1);
    cycle();
    checkEq("R3 still set", int'(overrun), 1);
    statusRead = 1; cycle();
    checkEq("R3 cleared by status", int'(overrun), 0);

    // R4: clear collides with an arrival into a full queue
    clrRx = 1; pushValid = 1; pushData = 8'h77; cycle();
    checkEq("R4 emptied", int'(fillLevel), 0);
    checkEq("R4 no overrun", int'(overrun), 0);

    // R10: read on empty
    popReq = 1; cycle();
    checkEq("R10 empty read", int'(fillLevel), 0);
    checkEq("R10 no irq", int'(dataIrq | timeoutIrq), 0);

    // R8 and R9: idle timeout
    trigSel = 2'b11;
    push1(8'hA1); push1(8'hA2);
    for (int k = 0; k < TMO - 1; k++) begin charTick = 1; cycle(); end
    checkEq("R8 early", int'(timeoutIrq), 0);
    charTick = 1; cycle();
    checkEq("R8 fires", int'(timeoutIrq), 1);
    popReq = 1; cycle();
    checkEq("R9 read drops", int'(timeoutIrq), 0);
    checkEq("R9 data remains", int'(rdData), 8'hA2);

    // R7: gating by the interrupt enable
    trigSel = 2'b00;
    for (int k = 0; k < TMO; k++) begin charTick = 1; cycle(); end
    dataIntEn = 0; cycle();
    checkEq("R7 gated", int'(dataIrq | timeoutIrq), 0);
    dataIntEn = 1; cycle();
    checkEq("R7 ungated", int'(dataIrq & timeoutIrq), 1);

    // R5: enable change in both directions
    fifoEn = 0; cycle();
    checkEq("R5 disable clears", int'(fillLevel), 0);
    push1(8'h5A);
    fifoEn = 1; cycle();
    checkEq("R5 enable clears", int'(fillLevel), 0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      r = int'($urandom_range(0, 99));
      pushValid  = ($urandom_range(0, 99) < 45);
      pushData   = 8'($urandom);
      pushParErr = 1'($urandom); pushFrmErr = 1'($urandom); pushBrk = 1'($urandom);
      popReq     = ($urandom_range(0, 99) < 35);
      charTick   = ($urandom_range(0, 99) < 30);
      statusRead = ($urandom_range(0, 99) < 5);
      clrRx      = (r == 0);
      if (r == 1) fifoEn = ~fifoEn;
      if (r == 2) dataIntEn = ~dataIntEn;
      if (r < 8) trigSel = 2'($urandom);
      cycle();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule